// File: doc/BRIEF.md
# Prioritised Event Interrupt Controller

This block merges up to eight numbered event sources into a single level-sensitive fast-interrupt request for an embedded processor. Each event arrives as a one-cycle pulse that carries its number. The block records the pulse in a pending mask and keeps an interrupt-number register, which the processor reads to find out which event to service. The request line stays high for as long as any event is pending.

Software acknowledges an event by writing the clear register repeatedly. Only every fourth write has an effect. That write retires the lowest-numbered pending event and points the number register at the lowest event still pending. The number register follows a deliberately simple update rule, so in some sequences it reports a value that is not the lowest pending event. The requirements below pin that rule down.

Top module: `prio_fiq_ctrl`

## Requirements
- R1: After reset, the pending mask holds only event 2 (value 0x04, where bit i stands for event i), the interrupt number reads 2, and the request line is high.
- R2: An event pulse with number i sets bit i of the pending mask. If the mask was empty, the request line rises with it.
- R3: On an event with number i, the interrupt number takes the value i when its current value is 0 or when i is smaller than its current value. Otherwise it keeps its current value.
- R4: A write to the clear register only counts. The first three writes of a group change no output. The fourth write performs an acknowledge, and counting restarts from zero after it.
- R5: An acknowledge clears only the lowest set bit of the pending mask.
- R6: After an acknowledge, the interrupt number takes the lowest bit still pending. If no bit remains, the interrupt number keeps its previous value and the request line falls.
- R7: An acknowledge performed while the mask is empty changes no output.
- R8: When an acknowledge and an event fall in the same cycle, the acknowledge is applied first and the event is merged into the result, including the interrupt-number rule of R3.
- R9: The request line is high exactly when the pending mask is non-zero.
- R10: Outputs change only at the clock edge that samples the input. An input driven between edges leaves the outputs unchanged until that edge.
- R11: The clear-write count is kept across event pulses, so events arriving between clear writes neither reset nor advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event pulse strobe |
| evtIdx | input | 3 | Number of the event carried by the pulse |
| clrWrite | input | 1 | Write strobe of the clear register |
| irqNum | output | 3 | Interrupt-number register |
| pendMask | output | 8 | Pending event mask, bit i for event i |
| fiq | output | 1 | Level fast-interrupt request |

## Verification
The bench steps through partial clear groups to confirm that the first three writes do nothing. A design that acknowledged on every write, or that reset the count when an event arrived, would drop pending bits too early. It forces the value-zero rule and the stale number left behind by an empty acknowledge, two cases where a "correct" priority encoder would report a different number than this block is required to. It places an event in the same cycle as an acknowledge that retires that event's own bit. A design that merged the event before clearing would lose the event. It also checks that the request line falls only when the last bit retires.

// File: rtl/prio_fiq_pkg.sv
package prio_fiq_pkg;

  // Strobes from the sequencing control into the datapath.
  typedef struct packed {
    logic ackFire;   // this cycle retires the lowest pending event
    logic evtFire;   // this cycle merges an incoming event
  } fiq_strobes_t;

endpackage

// File: rtl/prio_fiq_first.sv
// Finds the lowest set bit of a mask and reports its index.
module prio_fiq_first #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] mask,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_fiq_seq.sv
// Clear-write counting and strobe generation.
module prio_fiq_seq
  import prio_fiq_pkg::*;
#(
  parameter int CLEAR_WRITES = 4,
  localparam int CNT_W = (CLEAR_WRITES > 1) ? $clog2(CLEAR_WRITES) : 1,
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CLEAR_WRITES - 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtValid,
  input  logic         clrWrite,
  output fiq_strobes_t strobes
);

  logic [CNT_W-1:0] clrCnt;
  logic             groupDone;

  assign groupDone       = clrWrite && (clrCnt == LAST_CNT);
  assign strobes.ackFire = groupDone;
  assign strobes.evtFire = evtValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrCnt <= '0;
    end else if (clrWrite) begin
      if (groupDone) clrCnt <= '0;
      else           clrCnt <= clrCnt + 1'b1;
    end
  end

  // R4: the group count wraps to zero after the acknowledging write
  a_r4_count_wraps: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackFire |=> clrCnt == '0);

  // R4: a non-final write advances the count by one
  a_r4_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !strobes.ackFire) |=> clrCnt == $past(clrCnt) + 1'b1);

  // R11: events never disturb the count
  a_r11_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    !clrWrite |=> $stable(clrCnt));

endmodule

// File: rtl/prio_fiq_dp.sv
// Pending mask, interrupt-number register and request line.
module prio_fiq_dp
  import prio_fiq_pkg::*;
#(
  parameter int NUM_EVENTS  = 8,
  parameter int RESET_EVENT = 2,
  localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1,
  localparam logic [NUM_EVENTS-1:0] RESET_MASK = NUM_EVENTS'(1) << RESET_EVENT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fiq_strobes_t          strobes,
  input  logic [IDX_W-1:0]      evtIdx,
  output logic [IDX_W-1:0]      irqNum,
  output logic [NUM_EVENTS-1:0] pendMask,
  output logic                  fiq
);

  logic [NUM_EVENTS-1:0] lowOneHot;
  logic [NUM_EVENTS-1:0] remainMask;
  logic [NUM_EVENTS-1:0] afterClr;
  logic [NUM_EVENTS-1:0] evtOneHot;
  logic [NUM_EVENTS-1:0] pendNext;
  logic                  nextFound;
  logic [IDX_W-1:0]      nextIdx;
  logic [IDX_W-1:0]      irqAfterClr;
  logic [IDX_W-1:0]      irqNext;
  logic                  fiqNext;

  // Isolate the lowest pending bit and what would remain without it.
  assign lowOneHot  = pendMask & (~pendMask + 1'b1);
  assign remainMask = pendMask & ~lowOneHot;
  assign evtOneHot  = NUM_EVENTS'(1) << evtIdx;

  prio_fiq_first #(.WIDTH(NUM_EVENTS)) uNextFind (
    .mask  (remainMask),
    .found (nextFound),
    .idx   (nextIdx)
  );

  // Stage 1: acknowledge. Stage 2: event merge on top of it.
  always_comb begin
    afterClr    = pendMask;
    irqAfterClr = irqNum;
    fiqNext     = fiq;
    if (strobes.ackFire) begin
      afterClr = remainMask;
      if (nextFound) irqAfterClr = nextIdx;
      if (remainMask == '0) fiqNext = 1'b0;
    end
    pendNext = afterClr;
    irqNext  = irqAfterClr;
    if (strobes.evtFire) begin
      pendNext = afterClr | evtOneHot;
      if (irqAfterClr == '0 || evtIdx < irqAfterClr) irqNext = evtIdx;
      if (afterClr == '0) fiqNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask <= RESET_MASK;
      irqNum   <= IDX_W'(RESET_EVENT);
      fiq      <= 1'b1;
    end else begin
      pendMask <= pendNext;
      irqNum   <= irqNext;
      fiq      <= fiqNext;
    end
  end

  // R9: request line tracks a non-empty mask
  a_r9_fiq_level: assert property (@(posedge clk) disable iff (!rstN)
    fiq == (pendMask != '0));

  // R2: an event leaves its bit set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evtFire |=> pendMask[$past(evtIdx)]);

  // R5: a lone acknowledge retires exactly one bit
  a_r5_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackFire && !strobes.evtFire && pendMask != '0)
      |=> $countones(pendMask) == $countones($past(pendMask)) - 1);

  // R5: an acknowledge never sets a bit that was clear
  a_r5_no_new_bits: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackFire && !strobes.evtFire)
      |=> (pendMask & ~$past(pendMask)) == '0);

  // R7: no strobe, no change
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.ackFire && !strobes.evtFire)
      |=> ($stable(pendMask) && $stable(irqNum) && $stable(fiq)));

  // R3: an event alone never raises a non-zero number
  a_r3_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evtFire && !strobes.ackFire && irqNum != '0)
      |=> irqNum <= $past(irqNum));

endmodule

// File: rtl/prio_fiq_ctrl.sv
// Thin top: sequencing control plus datapath.
module prio_fiq_ctrl
  import prio_fiq_pkg::*;
#(
  parameter int NUM_EVENTS   = 8,
  parameter int CLEAR_WRITES = 4,
  parameter int RESET_EVENT  = 2,
  localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evtValid,
  input  logic [IDX_W-1:0]      evtIdx,
  input  logic                  clrWrite,
  output logic [IDX_W-1:0]      irqNum,
  output logic [NUM_EVENTS-1:0] pendMask,
  output logic                  fiq
);

  fiq_strobes_t strobes;

  prio_fiq_seq #(.CLEAR_WRITES(CLEAR_WRITES)) uSeq (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .clrWrite (clrWrite),
    .strobes  (strobes)
  );

  prio_fiq_dp #(
    .NUM_EVENTS  (NUM_EVENTS),
    .RESET_EVENT (RESET_EVENT)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .evtIdx   (evtIdx),
    .irqNum   (irqNum),
    .pendMask (pendMask),
    .fiq      (fiq)
  );

endmodule

// File: tb/prio_fiq_ctrl_test.sv
module prio_fiq_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evtValid = 1'b0;
  logic [2:0] evtIdx = '0;
  logic       clrWrite = 1'b0;
  logic [2:0] irqNum;
  logic [7:0] pendMask;
  logic       fiq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  prio_fiq_ctrl uut (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .evtIdx   (evtIdx),
    .clrWrite (clrWrite),
    .irqNum   (irqNum),
    .pendMask (pendMask),
    .fiq      (fiq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic [7:0] expMask, input logic [2:0] expIrq,
                       input logic expFiq, input string tag);
    testsRun++;
    if (pendMask !== expMask || irqNum !== expIrq || fiq !== expFiq) begin
      testsFailed++;
      $display("FAIL %s: mask=%02h irq=%0d fiq=%0b expected mask=%02h irq=%0d fiq=%0b",
               tag, pendMask, irqNum, fiq, expMask, expIrq, expFiq);
    end
  endtask

  // One cycle of stimulus, driven at a falling edge; results are sampled at the next falling edge.
  task automatic cycle(input logic ev, input logic [2:0] idx, input logic clr);
    @(negedge clk);
    evtValid = ev;
    evtIdx   = idx;
    clrWrite = clr;
    @(negedge clk);
    evtValid = 1'b0;
    clrWrite = 1'b0;
  endtask

  task automatic clears(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 3'd0, 1'b1);
  endtask

  task automatic testReset;
    check(8'h04, 3'd2, 1'b1, "R1 reset state");
  endtask

  task automatic testClearGroup;
    clears(3);
    check(8'h04, 3'd2, 1'b1, "R4 three writes ignored");
    clears(1);
    check(8'h00, 3'd2, 1'b0, "R6 R9 last bit retired, number held");
  endtask

  task automatic testEmptyAck;
    clears(4);
    check(8'h00, 3'd2, 1'b0, "R7 acknowledge on empty mask");
  endtask

  task automatic testEvents;
    cycle(1'b1, 3'd5, 1'b0);
    check(8'h20, 3'd2, 1'b1, "R2 R3 event 5 keeps stale number 2");
    cycle(1'b1, 3'd1, 1'b0);
    check(8'h22, 3'd1, 1'b1, "R3 smaller event replaces number");
    cycle(1'b1, 3'd3, 1'b0);
    check(8'h2A, 3'd1, 1'b1, "R3 larger event ignored for number");
  endtask

  task automatic testAckOrder;
    clears(4);
    check(8'h28, 3'd3, 1'b1, "R5 R6 lowest bit 1 retired");
    clears(4);
    check(8'h20, 3'd5, 1'b1, "R5 R6 bit 3 retired");
    clears(4);
    check(8'h00, 3'd5, 1'b0, "R6 R9 empty after last");
  endtask

  task automatic testZeroRule;
    cycle(1'b1, 3'd0, 1'b0);
    check(8'h01, 3'd0, 1'b1, "R3 event 0 taken");
    cycle(1'b1, 3'd6, 1'b0);
    check(8'h41, 3'd6, 1'b1, "R3 value 0 replaced by 6");
    clears(4);
    check(8'h40, 3'd6, 1'b1, "R5 bit 0 retired");
    clears(4);
    check(8'h00, 3'd6, 1'b0, "R6 empty");
  endtask

  task automatic testSameCycle;
    cycle(1'b1, 3'd4, 1'b0);
    cycle(1'b1, 3'd7, 1'b0);
    check(8'h90, 3'd4, 1'b1, "R3 events 4 and 7");
    clears(3);
    cycle(1'b1, 3'd4, 1'b1);
    check(8'h90, 3'd4, 1'b1, "R8 clear then re-set bit 4");
    clears(3);
    cycle(1'b1, 3'd2, 1'b1);
    check(8'h84, 3'd2, 1'b1, "R8 clear bit 4 then merge event 2");
    clears(4);
    check(8'h80, 3'd7, 1'b1, "R6 next pending 7");
    clears(4);
    check(8'h00, 3'd7, 1'b0, "R6 empty");
  endtask

  task automatic testLatency;
    @(negedge clk);
    evtValid = 1'b1;
    evtIdx   = 3'd3;
    #1;
    check(8'h00, 3'd7, 1'b0, "R10 no change before edge");
    @(negedge clk);
    evtValid = 1'b0;
    check(8'h08, 3'd3, 1'b1, "R10 R2 updated after edge");
  endtask

  task automatic testCountAcrossEvents;
    clears(2);
    cycle(1'b1, 3'd1, 1'b0);
    check(8'h0A, 3'd1, 1'b1, "R11 event between writes");
    clears(1);
    check(8'h0A, 3'd1, 1'b1, "R11 third write ignored");
    clears(1);
    check(8'h08, 3'd3, 1'b1, "R11 fourth write acknowledges");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClearGroup();
    testEmptyAck();
    testEvents();
    testAckOrder();
    testZeroRule();
    testSameCycle();
    testLatency();
    testCountAcrossEvents();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule